// File: doc/BRIEF.md
# Inertial Sensor Burst Reader

This block reads one complete sample set from an inertial sensor each time the sensor signals fresh data. A rising edge on the data-ready input starts a burst. The block then acts as SPI master. It sends a burst command word, clocks in a run of 16-bit words and checks them against the additive checksum that the sensor appends to the run.

The result is a frame of fifteen data words and a flag that says whether the checksum matched. A frame that fails the check is not passed on as it arrived. It is replaced by a frame of zeros with its lowest bit set, so the consumer cannot mistake it for real data. The block also counts checksums that look suspicious, one after another. When that run grows long enough, it asks the system to reset the sensor. Received frames and mismatches are also counted.

Top module: `imu_burst_reader`

## Requirements
- R1: A rising edge of `drdy` seen in idle, after a two-stage synchronizer, starts a burst. `cs_n` goes low and `sclk` is still high at that moment.
- R2: A burst is 17 words of 16 bits, MSB first, 272 `sclk` rising edges in all. The first word sent on `mosi` is 0x6800 and the other 16 words are 0x0000.
- R3: `sclk` is high whenever `cs_n` is high. Within a burst each half period of `sclk` lasts CLK_DIV system clocks. `mosi` changes on falling edges and `miso` is sampled on rising edges.
- R4: `cs_n` stays low for the whole burst. It rises one half period after the last rising edge of `sclk`. In that same cycle `frame_done` pulses high for exactly one cycle.
- R5: The first received word is discarded. Received word k, for k from 1 to 15, appears at `frame_data[16*(k-1) +: 16]`, so the status word sits in the lowest slot.
- R6: The computed checksum is the 16-bit wrapping sum of the upper byte plus the lower byte of received words 1 to 15. When it equals received word 16, `frame_ok` is 1 and `frame_data` carries the words unchanged.
- R7: When the checksums differ, `frame_ok` is 0 and `frame_data` is all zero except bit 0, which is 1.
- R8: A frame is suspicious when the checksums differ or when either checksum is zero. Each suspicious frame raises the fault count by one, saturating at FAULT_LIMIT (default 5). Any other frame clears the count to zero.
- R9: `sensor_rst_req` is high exactly while the fault count is at FAULT_LIMIT.
- R10: `rx_count` goes up by one for each completed frame. `err_count` goes up by one for each frame whose checksums differ. Both wrap at 16 bits.
- R11: A rising edge of `drdy` during a burst is ignored. It starts no second burst and adds no frame.
- R12: After reset, `cs_n` and `sclk` are 1. `frame_done`, `frame_ok`, `frame_data`, `sensor_rst_req`, `rx_count` and `err_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drdy | input | 1 | Data-ready from the sensor, asynchronous |
| sclk | output | 1 | SPI serial clock, idle high |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |
| frame_done | output | 1 | One-cycle pulse when a frame is ready |
| frame_ok | output | 1 | Checksum of the last frame matched |
| frame_data | output | 240 | Fifteen data words, status word in the lowest slot |
| sensor_rst_req | output | 1 | Request to reset the sensor |
| rx_count | output | 16 | Count of completed frames |
| err_count | output | 16 | Count of checksum mismatches |

## Verification
The assertions assume two things about the inputs. First, `rst_n` is held low for at least one clock before operation. Second, once `cs_n` falls, the sensor moves `miso` only after falling edges of `sclk`, so that a sample taken on a rising edge is stable. The bench slave model updates `miso` right after each falling edge of `sclk` and starts from bit 0 of word 0 whenever `cs_n` falls. It also holds `drdy` high for several clocks, so the synchronizer sees a clean edge.

// File: rtl/imu_burst_reader.sv
module imu_burst_reader #(
  parameter int          CLK_DIV     = 50,
  parameter int          DATA_WORDS  = 15,
  parameter int          FAULT_LIMIT = 5,
  parameter logic [15:0] CMD_WORD    = 16'h6800
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      drdy,
  output logic                      sclk,
  output logic                      cs_n,
  output logic                      mosi,
  input  logic                      miso,
  output logic                      frame_done,
  output logic                      frame_ok,
  output logic [16*DATA_WORDS-1:0]  frame_data,
  output logic                      sensor_rst_req,
  output logic [15:0]               rx_count,
  output logic [15:0]               err_count
);
  localparam int NW  = DATA_WORDS + 2;
  localparam int WW  = $clog2(NW + 1);
  localparam int DVW = $clog2(CLK_DIV + 1);
  localparam int SW  = $clog2(FAULT_LIMIT + 1);
  localparam int FW  = 16 * DATA_WORDS;

  typedef enum logic [1:0] {IDLE, SHIFT, TAIL} st_t;

  st_t              st;
  logic [2:0]       dr_q;
  logic [DVW-1:0]   div_cnt;
  logic [3:0]       bit_cnt;
  logic [WW-1:0]    word_cnt;
  logic [WW-1:0]    slot;
  logic [15:0]      tx_sh;
  logic [14:0]      rx_sh;
  logic [FW-1:0]    fbuf;
  logic [15:0]      sum;
  logic [15:0]      chk_rx;
  logic [SW-1:0]    sus;

  wire        tick    = div_cnt == DVW'(CLK_DIV - 1);
  wire [15:0] rx_word = {rx_sh, miso};
  wire        mism    = sum != chk_rx;
  wire        suspect = mism | (sum == 16'h0) | (chk_rx == 16'h0);

  assign slot           = word_cnt - WW'(1);
  assign mosi           = tx_sh[15];
  assign sensor_rst_req = sus == SW'(FAULT_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      dr_q       <= '0;
      div_cnt    <= '0;
      bit_cnt    <= '0;
      word_cnt   <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      fbuf       <= '0;
      sum        <= '0;
      chk_rx     <= '0;
      sus        <= '0;
      sclk       <= 1'b1;
      cs_n       <= 1'b1;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      frame_data <= '0;
      rx_count   <= '0;
      err_count  <= '0;
    end else begin
      frame_done <= 1'b0;
      dr_q       <= {dr_q[1:0], drdy};
      case (st)
        IDLE: begin
          if (dr_q[1] && !dr_q[2]) begin
            st       <= SHIFT;
            cs_n     <= 1'b0;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            word_cnt <= '0;
            sum      <= '0;
          end
        end
        SHIFT: begin
          div_cnt <= tick ? '0 : div_cnt + DVW'(1);
          if (tick) begin
            sclk <= ~sclk;
            if (sclk) begin
              if (bit_cnt == 4'd0)
                tx_sh <= (word_cnt == '0) ? CMD_WORD : 16'h0;
              else
                tx_sh <= {tx_sh[14:0], 1'b0};
            end else begin
              rx_sh   <= rx_word[14:0];
              bit_cnt <= bit_cnt + 4'd1;
              if (bit_cnt == 4'd15) begin
                word_cnt <= word_cnt + WW'(1);
                if (word_cnt != '0 && word_cnt <= WW'(DATA_WORDS)) begin
                  fbuf[slot*16 +: 16] <= rx_word;
                  sum <= sum + 16'(rx_word[15:8]) + 16'(rx_word[7:0]);
                end
                if (word_cnt == WW'(NW - 1)) begin
                  chk_rx <= rx_word;
                  st     <= TAIL;
                end
              end
            end
          end
        end
        TAIL: begin
          div_cnt <= tick ? '0 : div_cnt + DVW'(1);
          if (tick) begin
            st         <= IDLE;
            cs_n       <= 1'b1;
            frame_done <= 1'b1;
            frame_ok   <= !mism;
            frame_data <= mism ? FW'(1) : fbuf;
            rx_count   <= rx_count + 16'd1;
            if (mism) err_count <= err_count + 16'd1;
            if (suspect) sus <= sensor_rst_req ? sus : sus + SW'(1);
            else         sus <= '0;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imu_burst_reader_chk.sv
module imu_burst_reader_chk #(
  parameter int FW = 240
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          cs_n,
  input logic          frame_done,
  input logic          frame_ok,
  input logic [FW-1:0] frame_data,
  input logic [15:0]   rx_count,
  input logic [15:0]   err_count
);
  a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r1_cs_fall_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r4_cs_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> frame_done);

  a_r7_bad_frame_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ok) |-> frame_data == FW'(1));

  a_r10_rx_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> rx_count == $past(rx_count) + 16'd1);

  a_r10_err_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_ok) |-> err_count == $past(err_count) + 16'd1);
endmodule

bind imu_burst_reader imu_burst_reader_chk #(.FW(16*DATA_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
  .frame_done(frame_done), .frame_ok(frame_ok), .frame_data(frame_data),
  .rx_count(rx_count), .err_count(err_count)
);

// File: tb/sim_imu_burst_reader.sv
module sim_imu_burst_reader;
  localparam int DIV = 4;
  localparam int NV  = 10;
  // {seed, mode}: mode 0 good, 1 checksum corrupted, 2 all-zero frame
  localparam logic [17:0] VEC [NV] = '{
    {16'h1234, 2'd0}, {16'hBEEF, 2'd0}, {16'h0F0F, 2'd1}, {16'h0000, 2'd2},
    {16'hA5A5, 2'd1}, {16'h5A5A, 2'd1}, {16'h7777, 2'd1}, {16'hC001, 2'd0},
    {16'hFFFF, 2'd0}, {16'h2468, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, drdy = 1'b0, miso = 1'b0;
  logic sclk, cs_n, mosi, frame_done, frame_ok, sensor_rst_req;
  logic [239:0] frame_data;
  logic [15:0] rx_count, err_count;

  always #5 clk = ~clk;

  imu_burst_reader #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .drdy(drdy), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .frame_done(frame_done), .frame_ok(frame_ok),
    .frame_data(frame_data), .sensor_rst_req(sensor_rst_req),
    .rx_count(rx_count), .err_count(err_count)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] tx_words [17];
  logic [15:0] cap_words [17];
  int rise_cnt = 0;
  time t_fall = 0, low_w = 0;

  task automatic chk(input string req, input logic [239:0] act, input logic [239:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge cs_n);
      rise_cnt = 0;
      for (int w = 0; w < 17; w++)
        for (int b = 15; b >= 0; b--) begin
          @(negedge sclk);
          t_fall = $time;
          miso = tx_words[w][b];
          @(posedge sclk);
          low_w = $time - t_fall;
          cap_words[w][b] = mosi;
          rise_cnt++;
        end
    end
  end

  task automatic pulse_drdy();
    @(negedge clk) drdy = 1'b1;
    repeat (4) @(negedge clk);
    drdy = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!frame_done && t < 20000) begin @(negedge clk); t++; end
    if (!frame_done) chk("R4 frame_done timeout", 240'd0, 240'd1);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sus = 0;
    logic [15:0] erx = 0, eerr = 0;
    repeat (4) @(negedge clk);
    chk("R12 cs_n", 240'(cs_n), 240'd1);
    chk("R12 sclk", 240'(sclk), 240'd1);
    chk("R12 outputs", {frame_done, frame_ok, sensor_rst_req, rx_count, err_count, frame_data[195:0]}, 240'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] seed, csum;
      logic [1:0]  mode;
      logic [239:0] expd;
      logic mism, susp;
      seed = VEC[v][17:2];
      mode = VEC[v][1:0];
      csum = 16'h0;
      tx_words[0] = 16'hDEAD;
      for (int k = 1; k <= 15; k++) begin
        tx_words[k] = (mode == 2'd2) ? 16'h0 : (seed ^ 16'(k * 16'h1357));
        csum = csum + 16'(tx_words[k][15:8]) + 16'(tx_words[k][7:0]);
        expd[16*(k-1) +: 16] = tx_words[k];
      end
      tx_words[16] = (mode == 2'd1) ? csum + 16'd1 : csum;
      mism = (mode == 2'd1);
      susp = mism || csum == 16'h0 || tx_words[16] == 16'h0;
      if (mism) expd = 240'd1;
      sus = susp ? ((sus == 5) ? 5 : sus + 1) : 0;
      erx++;
      if (mism) eerr++;
      pulse_drdy();
      wait_done();
      chk("R6 frame_ok", 240'(frame_ok), 240'(!mism));
      chk(mism ? "R7 marked frame" : "R5 frame_data", frame_data, expd);
      chk("R9 sensor_rst_req R8", 240'(sensor_rst_req), 240'(sus == 5));
      chk("R10 rx_count", 240'(rx_count), 240'(erx));
      chk("R10 err_count", 240'(err_count), 240'(eerr));
      chk("R2 command word", 240'(cap_words[0]), 240'h6800);
      if (v == 0) begin
        logic any;
        any = 1'b0;
        for (int w = 1; w < 17; w++) any = any | (|cap_words[w]);
        chk("R2 zero words", 240'(any), 240'd0);
        chk("R2 rising edges", 240'(rise_cnt), 240'd272);
        chk("R3 half period", 240'(low_w), 240'(DIV * 10));
      end
      @(negedge clk);
      chk("R4 done one cycle, cs released", {frame_done, cs_n}, 240'b01);
    end

    begin
      int lows = 0;
      erx++;
      pulse_drdy();
      repeat (600) @(negedge clk);
      pulse_drdy();
      wait_done();
      @(negedge clk);
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (!cs_n || frame_done) lows++;
      end
      chk("R11 no second burst", 240'(lows), 240'd0);
      chk("R11 rx_count", 240'(rx_count), 240'(erx));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule